// File: doc/BRIEF.md
# DAC Channel Power and Shared Reference Controller

This block sits behind a command decoder in a multi-channel converter. It receives 32-bit command frames, one per cycle when `cmd_valid` is high. It holds two things: a 2-bit power mode for each of eight output channels, and the operating mode of one on-chip voltage reference that the channels share. All other frame types pass through it with no effect. Frame reception, sample data registers and the analog outputs belong to other blocks.

Two schemes control the reference. In the static scheme, one bit either keeps the reference off or makes it follow the channels. In the flexible scheme, a 3-bit code selects following, forced on or forced off. When the reference follows the channels, it is enabled while at least one channel is powered up and disabled once every channel is powered down. The enable output is decoded without a register from the stored reference mode and the stored channel modes. It therefore changes in the same cycle as the channel modes it depends on.

Top module: `dac_pwr_ref_ctrl`

## Requirements
- R1: After a synchronous reset every channel is in mode 00, the reference is in the static scheme with the reference off, and `ref_en` is 0.
- R2: A frame with bits 27:24 = 0100 writes the mode in bits 9:8 into every channel whose bit in the mask field, bits 7:0, is 1. Channel 0 is mask bit 0 and appears at `ch_mode[1:0]`. Channels whose mask bit is 0 keep their mode. The modes are 00 = powered up, 01 = down with 1 kΩ to ground, 10 = down with 100 kΩ to ground, 11 = down with high impedance.
- R3: In the static scheme, a frame with bits 27:24 = 1000 and bit 0 = 1 makes the reference follow the channels. The same frame with bit 0 = 0 turns the reference off, and `ref_en` is then 0.
- R4: Whenever the reference follows the channels, `ref_en` is 1 exactly when at least one channel is in mode 00.
- R5: A frame with bits 27:24 = 1001 enters the flexible scheme according to bits 19:17. Code 100 makes the reference follow the channels. Code 101 holds `ref_en` at 1 and code 110 holds it at 0, whatever the channel states.
- R6: A frame with bits 27:24 = 1001 and bits 19:17 = 000 puts the reference back in the static scheme with the reference off. After that, frames with bits 27:24 = 1000 are accepted again.
- R7: In the flexible scheme, frames with bits 27:24 = 1000 change nothing.
- R8: Frames with bits 27:24 = 1001 and bits 19:17 equal to 001, 010, 011 or 111 change nothing.
- R9: A frame changes nothing if `cmd_valid` is 0, if bit 31 is 1, or if bits 27:24 hold any command other than 0100, 1000 or 1001.
- R10: `ch_mode` and `ref_en` both show the effect of a frame in the cycle after the edge that captures it. `ref_en` adds no cycle of delay beyond the channel modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Frame on `cmd_frame` is present this cycle |
| cmd_frame | input | 32 | Decoded command frame |
| ch_mode | output | 2*NCH | Power mode per channel, channel i at bits 2i+1:2i |
| ref_en | output | 1 | Enable for the shared reference |

## Verification
The hardest condition to reach is the falling edge of `ref_en` while the reference follows the channels. That edge needs all eight channels powered down at once, with no forcing code in effect. The stimulus powers the channels down in two masked groups using different down modes, then powers a single channel back up to see the enable return. It then repeats the all-down state under the forced-on code to show that forcing overrides following. A behavioural model in the bench tracks every channel and the reference scheme, and is compared with the outputs on every cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int FRAME_W  = 32;
  localparam int MASK_W   = 8;
  localparam int OP_LSB   = 24;
  localparam int FX_LSB   = 17;
  localparam int PM_LSB   = 8;
  localparam logic [3:0] OP_PWR    = 4'b0100;
  localparam logic [3:0] OP_REF_ST = 4'b1000;
  localparam logic [3:0] OP_REF_FX = 4'b1001;

  typedef enum logic [1:0] {
    PM_UP     = 2'b00,
    PM_PD1K   = 2'b01,
    PM_PD100K = 2'b10,
    PM_HIZ    = 2'b11
  } pwr_mode_e;

  typedef enum logic [2:0] {
    RM_ST_OFF = 3'd0,
    RM_ST_TRK = 3'd1,
    RM_FX_TRK = 3'd2,
    RM_FX_ON  = 3'd3,
    RM_FX_OFF = 3'd4
  } ref_mode_e;

  typedef struct packed {
    logic              pwr_wr;
    pwr_mode_e         pwr_mode;
    logic [MASK_W-1:0] mask;
    logic              st_wr;
    logic              st_on;
    logic              fx_wr;
    logic [2:0]        fx_code;
  } dpr_cmd_t;
endpackage

// File: rtl/dpr_decode.sv
module dpr_decode
  import dpr_pkg::*;
(
  input  logic               valid,
  input  logic [FRAME_W-1:0] frame,
  output dpr_cmd_t           cmd
);
  logic       ok;
  logic [3:0] op;

  always_comb begin
    op  = frame[OP_LSB +: 4];
    ok  = valid && !frame[FRAME_W-1];
    cmd.pwr_wr   = ok && (op == OP_PWR);
    cmd.pwr_mode = pwr_mode_e'(frame[PM_LSB +: 2]);
    cmd.mask     = frame[MASK_W-1:0];
    cmd.st_wr    = ok && (op == OP_REF_ST);
    cmd.st_on    = frame[0];
    cmd.fx_wr    = ok && (op == OP_REF_FX);
    cmd.fx_code  = frame[FX_LSB +: 3];
  end
endmodule

// File: rtl/dpr_chan_bank.sv
module dpr_chan_bank
  import dpr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  pwr_mode_e        mode_in,
  input  logic [NCH-1:0]   mask,
  output logic [2*NCH-1:0] modes,
  output logic             any_up
);
  pwr_mode_e      mode_q [NCH];
  logic [NCH-1:0] up_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                  mode_q[i] <= PM_UP;
      else if (wr && mask[i])   mode_q[i] <= mode_in;
    end
    assign modes[2*i +: 2] = mode_q[i];
    assign up_vec[i]       = (mode_q[i] == PM_UP);

    // R2: a selected channel takes the commanded mode
    a_r2_masked_takes: assert property (@(posedge clk) disable iff (rst)
      (wr && mask[i]) |=> (mode_q[i] == $past(mode_in)));
    // R2 / R9: an unselected channel holds its mode
    a_r2_unmasked_holds: assert property (@(posedge clk) disable iff (rst)
      !(wr && mask[i]) |=> $stable(mode_q[i]));
  end

  assign any_up = |up_vec;
endmodule

// File: rtl/dpr_ref_ctrl.sv
module dpr_ref_ctrl
  import dpr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       st_wr,
  input  logic       st_on,
  input  logic       fx_wr,
  input  logic [2:0] fx_code,
  input  logic       any_up,
  output logic       ref_en
);
  ref_mode_e mode_q;
  logic      in_flex;

  assign in_flex = (mode_q == RM_FX_TRK) || (mode_q == RM_FX_ON) || (mode_q == RM_FX_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RM_ST_OFF;
    end else if (st_wr && !in_flex) begin
      mode_q <= st_on ? RM_ST_TRK : RM_ST_OFF;
    end else if (fx_wr) begin
      case (fx_code)
        3'b100:  mode_q <= RM_FX_TRK;
        3'b101:  mode_q <= RM_FX_ON;
        3'b110:  mode_q <= RM_FX_OFF;
        3'b000:  mode_q <= RM_ST_OFF;
        default: mode_q <= mode_q;
      endcase
    end
  end

  always_comb begin
    case (mode_q)
      RM_ST_TRK, RM_FX_TRK: ref_en = any_up;
      RM_FX_ON:             ref_en = 1'b1;
      default:              ref_en = 1'b0;
    endcase
  end

  // R7: static commands leave the flexible scheme untouched
  a_r7_static_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_wr && in_flex) |=> $stable(mode_q));
  // R8: unused flexible codes hold state
  a_r8_bad_code_holds: assert property (@(posedge clk) disable iff (rst)
    (fx_wr && !(fx_code inside {3'b000, 3'b100, 3'b101, 3'b110})) |=> $stable(mode_q));
  // R6: code 000 returns to static with the reference off
  a_r6_back_to_static: assert property (@(posedge clk) disable iff (rst)
    (fx_wr && fx_code == 3'b000) |=> (mode_q == RM_ST_OFF && !ref_en));
  // R4: enable only with a live channel unless forced on
  a_r4_en_needs_source: assert property (@(posedge clk) disable iff (rst)
    ref_en |-> (any_up || mode_q == RM_FX_ON));
endmodule

// File: rtl/dac_pwr_ref_ctrl.sv
module dac_pwr_ref_ctrl
  import dpr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_frame,
  output logic [2*NCH-1:0] ch_mode,
  output logic             ref_en
);
  dpr_cmd_t cmd;
  logic     any_up;

  dpr_decode u_dec (
    .valid (cmd_valid),
    .frame (cmd_frame),
    .cmd   (cmd)
  );

  dpr_chan_bank #(.NCH(NCH)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr      (cmd.pwr_wr),
    .mode_in (cmd.pwr_mode),
    .mask    (cmd.mask[NCH-1:0]),
    .modes   (ch_mode),
    .any_up  (any_up)
  );

  dpr_ref_ctrl u_ref (
    .clk     (clk),
    .rst     (rst),
    .st_wr   (cmd.st_wr),
    .st_on   (cmd.st_on),
    .fx_wr   (cmd.fx_wr),
    .fx_code (cmd.fx_code),
    .any_up  (any_up),
    .ref_en  (ref_en)
  );

  // R9: a rejected frame leaves all channel modes unchanged
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !cmd.pwr_wr |=> $stable(ch_mode));
endmodule

// File: tb/dac_pwr_ref_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_pwr_ref_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_frame = '0;
  logic [15:0] ch_mode;
  logic        ref_en;

  int n_chk = 0;
  int n_bad = 0;
  int mdl_ch [8];
  int mdl_ref = 0;   // 0 st off,1 st follow,2 fx follow,3 fx on,4 fx off
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  dac_pwr_ref_ctrl dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_frame(cmd_frame),
    .ch_mode(ch_mode), .ref_en(ref_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mdl_en();
    bit any = 1'b0;
    foreach (mdl_ch[i]) if (mdl_ch[i] == 0) any = 1'b1;
    case (mdl_ref)
      1, 2:    return int'(any);
      3:       return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int mdl_vec();
    int v = 0;
    for (int i = 0; i < 8; i++) v |= (mdl_ch[i] & 3) << (2*i);
    return v;
  endfunction

  function automatic void mdl_apply(input bit v, input logic [31:0] f);
    if (!v || f[31]) return;
    case (f[27:24])
      4'b0100: for (int i = 0; i < 8; i++) if (f[i]) mdl_ch[i] = int'(f[9:8]);
      4'b1000: if (mdl_ref < 2) mdl_ref = f[0] ? 1 : 0;
      4'b1001: case (f[19:17])
                 3'b100: mdl_ref = 2;
                 3'b101: mdl_ref = 3;
                 3'b110: mdl_ref = 4;
                 3'b000: mdl_ref = 0;
                 default: ;
               endcase
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] f_pwr(input logic [1:0] m, input logic [7:0] mask);
    return {4'h0, 4'b0100, 14'h0, m, mask};
  endfunction
  function automatic logic [31:0] f_st(input bit on);
    return {4'h0, 4'b1000, 23'h0, on};
  endfunction
  function automatic logic [31:0] f_fx(input logic [2:0] c);
    return {4'h0, 4'b1001, 4'h0, c, 17'h0};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 channel modes", int'(ch_mode), mdl_vec());
      check("R4 reference enable", int'(ref_en), mdl_en());
    end
  end

  task automatic send(input bit v, input logic [31:0] f);
    @(negedge clk);
    cmd_valid = v;
    cmd_frame = f;
    @(posedge clk);
    mdl_apply(v, f);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_frame = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    foreach (mdl_ch[i]) mdl_ch[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset modes", int'(ch_mode), 0);
    check("R1 reset ref_en", int'(ref_en), 0);
    cmp_on = 1'b1;

    send(1, f_st(1'b1));
    check("R3 static follow on", int'(ref_en), 1);
    send(1, f_pwr(2'b01, 8'h0F));
    check("R2 low group 1k", int'(ch_mode), 16'h0055);
    check("R10 ref_en same cycle", int'(ref_en), 1);
    send(1, f_pwr(2'b11, 8'hF0));
    check("R2 high group hiZ", int'(ch_mode), 16'hFF55);
    check("R4 all down ref off", int'(ref_en), 0);
    send(1, f_pwr(2'b00, 8'h20));
    check("R4 one up ref on", int'(ref_en), 1);
    check("R2 ch5 up", int'(ch_mode), 16'hF355);
    send(1, f_st(1'b0));
    check("R3 static off", int'(ref_en), 0);

    send(1, f_fx(3'b101));
    check("R5 forced on", int'(ref_en), 1);
    send(1, f_pwr(2'b10, 8'h20));
    check("R5 forced on all down", int'(ref_en), 1);
    send(1, f_st(1'b0));
    check("R7 static ignored in flex", int'(ref_en), 1);
    send(1, f_fx(3'b011));
    check("R8 code 011 ignored", int'(ref_en), 1);
    send(1, f_fx(3'b111));
    check("R8 code 111 ignored", int'(ref_en), 1);

    send(1, f_fx(3'b110) | 32'h8000_0000);
    check("R9 bit31 frame ignored", int'(ref_en), 1);
    send(0, f_fx(3'b110));
    check("R9 invalid strobe ignored", int'(ref_en), 1);
    send(1, {4'h0, 4'b0011, 24'h0000FF});
    check("R9 other command ignored", int'(ch_mode), 16'hFB55);
    send(0, f_pwr(2'b00, 8'hFF));
    check("R9 pwr without valid", int'(ch_mode), 16'hFB55);

    send(1, f_fx(3'b110));
    send(1, f_pwr(2'b00, 8'hFF));
    check("R5 forced off all up", int'(ref_en), 0);
    send(1, f_fx(3'b100));
    check("R5 flex follow", int'(ref_en), 1);
    send(1, f_pwr(2'b10, 8'hFF));
    check("R5 flex follow all down", int'(ref_en), 0);
    send(1, f_pwr(2'b00, 8'h01));
    send(1, f_fx(3'b000));
    check("R6 back to static off", int'(ref_en), 0);
    send(1, f_st(1'b1));
    check("R6 static accepted again", int'(ref_en), 1);

    rst = 1'b1;
    cmp_on = 1'b0;
    @(posedge clk);
    foreach (mdl_ch[i]) mdl_ch[i] = 0;
    mdl_ref = 0;
    @(negedge clk);
    check("R1 reset again modes", int'(ch_mode), 0);
    check("R1 reset again ref_en", int'(ref_en), 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    send(1, f_pwr(2'b01, 8'h80));
    check("R1 static off after reset", int'(ref_en), 0);
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule